// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel characters. It runs entirely on the receive clock, which is 1, 16, 32 or 64 times the bit rate. Each clock edge is one receive tick, and the serial input is assumed to be already synchronous to that clock. The block assembles characters of 5 to 8 data bits, plus an optional parity bit that can be even or odd.

A falling line is confirmed half a bit later before the block commits to a character. This keeps short glitches from being taken as start bits. When a stop bit is found low, the character is stored with a framing flag and the block stops watching the line for half a bit. An all-zero frame is reported as a line break, with one pulse when the break begins and another when it ends.

Finished characters go into a three-entry queue. Each entry carries its own parity, framing and overrun flags. Software or a DMA engine drains the queue with a simple pop strobe.

Top module: `async_rx_core`

## Requirements
- R1: The length code `cfg_len` selects 5, 6, 7 or 8 data bits (codes 0, 1, 2, 3). Data bits arrive LSB first and are stored right-aligned, with every unused upper bit read as zero.
- R2: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd` = 0 asks for an even count of ones over data plus parity, and 1 asks for an odd count. A mismatch sets `rx_perr` on that character's entry.
- R3: The multiplier code `cfg_mult` selects x1, x16, x32 or x64 (codes 0, 1, 2, 3). In the oversampled modes the first sample is taken M/2 ticks after the tick that first sees the line low, and each later bit is sampled M ticks after the one before. In x1 mode every following tick samples the next bit. `char_done` is therefore high in the cycle that begins 1 + M/2 + M*(data bits + parity bits + 1) clock edges after the first low tick, where M/2 is 0 in x1 mode.
- R4: In the oversampled modes, a low that is no longer present at the half-bit recheck starts no character.
- R5: A stop bit sampled low stores the character with `rx_ferr` = 1. A high stop bit stores it with `rx_ferr` = 0.
- R6: After a framing error that is not a break, the line is ignored for M/2 ticks following the stop sample. The search for a start bit resumes only after that.
- R7: The queue holds up to three entries and returns them first in, first out. `rx_valid` is high while it is not empty. `rd_en` with `rx_valid` high removes the head entry at the clock edge.
- R8: When a character completes while three entries are held and none is being removed, the newest entry is replaced by the new character with `rx_ovr` = 1. The two older entries are unchanged.
- R9: A frame whose data bits, parity bit (if enabled) and stop bit are all zero is a break. It is stored as zero with `rx_ferr` = 1 and pulses `brk_begin` for one cycle together with `char_done`. `brk_end` pulses once at the first tick that sees the line high again.
- R10: `char_done` pulses for exactly one cycle for each stored character.
- R11: After reset the queue is empty, `rx_valid` is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, M ticks per bit |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial data line, idle high |
| cfg_len | input | 2 | Data length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_mult | input | 2 | Clock multiplier code |
| rd_en | input | 1 | Pop the head entry |
| rx_valid | output | 1 | Queue holds at least one entry |
| rx_data | output | 8 | Head entry character |
| rx_perr | output | 1 | Head entry parity error |
| rx_ferr | output | 1 | Head entry framing error |
| rx_ovr | output | 1 | Head entry overrun |
| char_done | output | 1 | One-cycle pulse per stored character |
| brk_begin | output | 1 | One-cycle pulse at break start |
| brk_end | output | 1 | One-cycle pulse at break end |

## Verification
A table of frames sweeps every length, every multiplier, both parity senses, and correct versus corrupted parity bits. For each frame the bench checks the stored value and flags, and also the exact cycle of `char_done`. An error in the centre-sampling offset therefore shows up as a shifted pulse even when the data still happens to decode correctly.

A spike that stays low for exactly half a bit tests the rejection boundary. A framing-error frame followed back to back by a frame with no idle gap shows the half-bit hold-off as a one-tick shift in the second frame's completion; without the hold-off that completion would come seven ticks early. Four unread frames test the overrun replacement, and a long low line tests both break pulses and the stored zero character.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

    localparam int unsigned DATA_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_DATA  = 3'd2,
        ST_PAR   = 3'd3,
        ST_STOP  = 3'd4,
        ST_HOLD  = 3'd5,
        ST_BRK   = 3'd6
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              ovr;
    } rx_entry_t;

endpackage

// File: rtl/rxa_deframer.sv
module rxa_deframer
    import rxa_pkg::*;
#(
    parameter int unsigned MAX_MULT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_mult,
    output logic       push,
    output rx_entry_t  push_entry,
    output logic       brk_begin,
    output logic       brk_end
);
    localparam int unsigned CNT_W = $clog2(MAX_MULT);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  bidx;
        logic [DATA_W-1:0] shf;
        logic              par_bit;
        logic              push;
        rx_entry_t         ent;
        logic              bb;
        logic              be;
    } df_state_t;

    df_state_t st_d, st_q;
    logic [CNT_W-1:0] full_m1;
    logic [CNT_W-1:0] half_m1;
    logic [IDX_W-1:0] last_idx;
    logic             oversampled;

    // Tick counts per bit (minus one) for each multiplier code
    always_comb begin
        case (cfg_mult)
            2'd1:    begin full_m1 = CNT_W'(MAX_MULT/4 - 1); half_m1 = CNT_W'(MAX_MULT/8 - 1);  end
            2'd2:    begin full_m1 = CNT_W'(MAX_MULT/2 - 1); half_m1 = CNT_W'(MAX_MULT/4 - 1);  end
            2'd3:    begin full_m1 = CNT_W'(MAX_MULT - 1);   half_m1 = CNT_W'(MAX_MULT/2 - 1);  end
            default: begin full_m1 = '0;                     half_m1 = '0;                      end
        endcase
        oversampled = (cfg_mult != 2'd0);
        last_idx    = IDX_W'(cfg_len) + IDX_W'(DATA_W - 4);
    end

    always_comb begin
        st_d      = st_q;
        st_d.push = 1'b0;
        st_d.bb   = 1'b0;
        st_d.be   = 1'b0;
        case (st_q.st)
            ST_IDLE: begin
                if (!rxd) begin
                    st_d.shf  = '0;
                    st_d.bidx = '0;
                    if (oversampled) begin
                        st_d.st  = ST_START;
                        st_d.cnt = half_m1;
                    end else begin
                        st_d.st  = ST_DATA;
                        st_d.cnt = '0;
                    end
                end
            end
            ST_START: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else if (rxd) begin
                    st_d.st = ST_IDLE;             // glitch, not a start bit
                end else begin
                    st_d.st  = ST_DATA;
                    st_d.cnt = full_m1;
                end
            end
            ST_DATA: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.shf[st_q.bidx] = rxd;
                    st_d.cnt            = full_m1;
                    if (st_q.bidx == last_idx) begin
                        st_d.st = cfg_par_en ? ST_PAR : ST_STOP;
                    end else begin
                        st_d.bidx = st_q.bidx + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.par_bit = rxd;
                    st_d.cnt     = full_m1;
                    st_d.st      = ST_STOP;
                end
            end
            ST_STOP: begin
                if (st_q.cnt != '0) begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.push      = 1'b1;
                    st_d.ent.data  = st_q.shf;
                    st_d.ent.perr  = cfg_par_en & ((^st_q.shf ^ st_q.par_bit) != cfg_par_odd);
                    st_d.ent.ferr  = !rxd;
                    st_d.ent.ovr   = 1'b0;
                    if (rxd) begin
                        st_d.st = ST_IDLE;
                    end else if (st_q.shf == '0 && !(cfg_par_en && st_q.par_bit)) begin
                        st_d.st = ST_BRK;
                        st_d.bb = 1'b1;
                    end else if (oversampled) begin
                        st_d.st  = ST_HOLD;
                        st_d.cnt = half_m1;
                    end else begin
                        st_d.st = ST_IDLE;
                    end
                end
            end
            ST_HOLD: begin
                if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
                else                st_d.st  = ST_IDLE;
            end
            ST_BRK: begin
                if (rxd) begin
                    st_d.be = 1'b1;
                    st_d.st = ST_IDLE;
                end
            end
            default: st_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push       = st_q.push;
    assign push_entry = st_q.ent;
    assign brk_begin  = st_q.bb;
    assign brk_end    = st_q.be;

endmodule

// File: rtl/rxa_fifo.sv
module rxa_fifo
    import rxa_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      rd_en,
    output logic      valid,
    output rx_entry_t head
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic      [CW-1:0]    cnt;
    } fifo_state_t;

    fifo_state_t fs_d, fs_q;
    logic [CW-1:0] lvl;

    always_comb begin
        fs_d = fs_q;
        if (rd_en && fs_q.cnt != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                fs_d.mem[i] = fs_q.mem[i+1];
            end
            fs_d.cnt = fs_q.cnt - 1'b1;
        end
        lvl = fs_d.cnt;
        if (push) begin
            if (lvl == CW'(DEPTH)) begin
                fs_d.mem[DEPTH-1]     = push_entry;
                fs_d.mem[DEPTH-1].ovr = 1'b1;
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (lvl == CW'(i)) fs_d.mem[i] = push_entry;
                end
                fs_d.cnt = lvl + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= '0;
        else        fs_q <= fs_d;
    end

    assign valid = (fs_q.cnt != '0);
    assign head  = fs_q.mem[0];

endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
    import rxa_pkg::*;
#(
    parameter int unsigned MAX_MULT   = 64,
    parameter int unsigned FIFO_DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_mult,
    input  logic              rd_en,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_ovr,
    output logic              char_done,
    output logic              brk_begin,
    output logic              brk_end
);
    logic      push;
    rx_entry_t push_entry;
    rx_entry_t head;

    rxa_deframer #(.MAX_MULT(MAX_MULT)) i_deframer (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd         (rxd),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_mult    (cfg_mult),
        .push        (push),
        .push_entry  (push_entry),
        .brk_begin   (brk_begin),
        .brk_end     (brk_end)
    );

    rxa_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_entry (push_entry),
        .rd_en      (rd_en),
        .valid      (rx_valid),
        .head       (head)
    );

    assign char_done = push;
    assign rx_data   = head.data;
    assign rx_perr   = head.perr;
    assign rx_ferr   = head.ferr;
    assign rx_ovr    = head.ovr;

endmodule

// File: rtl/async_rx_checker.sv
module async_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic rxd,
    input logic rx_valid,
    input logic char_done,
    input logic brk_begin,
    input logic brk_end
);
    logic in_brk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         in_brk_q <= 1'b0;
        else if (brk_begin) in_brk_q <= 1'b1;
        else if (brk_end)   in_brk_q <= 1'b0;
    end

    AST_DONE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> rx_valid);                                      // R7
    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !char_done) |=> !rx_valid);                     // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        char_done |=> !char_done);                                    // R10
    AST_BRK_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        brk_begin |-> char_done);                                     // R9
    AST_BRK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        brk_begin |=> !brk_begin);                                    // R9
    AST_BRK_END_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> $past(rxd));                                      // R9
    AST_BRK_END_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |-> in_brk_q);                                        // R9

endmodule

bind async_rx_core async_rx_checker i_async_rx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rxd       (rxd),
    .rx_valid  (rx_valid),
    .char_done (char_done),
    .brk_begin (brk_begin),
    .brk_end   (brk_end)
);

// File: tb/test_async_rx_core.sv
module test_async_rx_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_mult = 2'd1;
    logic       rd_en = 1'b0;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_ovr;
    logic       char_done, brk_begin, brk_end;

    int checks = 0;
    int errors = 0;
    int neg_cnt = 0;
    int done_cnt = 0;
    int last_done = 0;
    int bb_cnt = 0;
    int be_cnt = 0;
    int frame_neg = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    async_rx_core i_async_rx_core (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_mult(cfg_mult), .rd_en(rd_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .char_done(char_done),
        .brk_begin(brk_begin), .brk_end(brk_end)
    );

    always @(negedge clk) begin
        neg_cnt <= neg_cnt + 1;
        if (char_done) begin
            done_cnt  <= done_cnt + 1;
            last_done <= neg_cnt;
        end
        if (brk_begin) bb_cnt <= bb_cnt + 1;
        if (brk_end)   be_cnt <= be_cnt + 1;
    end

    // fields: mult, len, par_en, par_odd, bad_parity, data sent, data expected
    localparam int NV = 9;
    localparam logic [22:0] VECS [NV] = '{
        {2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
        {2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h1F},
        {2'd2, 2'd2, 1'b1, 1'b0, 1'b0, 8'h5A, 8'h5A},
        {2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 8'h33, 8'h33},
        {2'd3, 2'd1, 1'b1, 1'b1, 1'b0, 8'h2C, 8'h2C},
        {2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 8'h81, 8'h81},
        {2'd0, 2'd3, 1'b0, 1'b0, 1'b0, 8'hC3, 8'hC3},
        {2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 8'h15, 8'h15},
        {2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ticks(input logic [1:0] mc);
        return (mc == 2'd0) ? 1 : (16 << (mc - 1));
    endfunction

    task automatic send_frame(input logic [1:0] mc, input logic [1:0] lc,
                              input logic pen, input logic podd, input logic badp,
                              input logic [7:0] d, input logic stopb, input int idle_bits);
        int m;
        int n;
        logic p;
        m = ticks(mc);
        n = 5 + int'(lc);
        p = podd ^ badp;
        for (int i = 0; i < n; i++) p = p ^ d[i];
        cfg_mult = mc; cfg_len = lc; cfg_par_en = pen; cfg_par_odd = podd;
        @(negedge clk);
        frame_neg = neg_cnt;
        rxd = 1'b0;
        repeat (m - 1) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); rxd = d[i];
            repeat (m - 1) @(negedge clk);
        end
        if (pen) begin
            @(negedge clk); rxd = p;
            repeat (m - 1) @(negedge clk);
        end
        @(negedge clk); rxd = stopb;
        repeat (m - 1) @(negedge clk);
        for (int i = 0; i < idle_bits * m; i++) begin
            @(negedge clk); rxd = 1'b1;
        end
    endtask

    task automatic pop(output logic v, output logic [7:0] d,
                       output logic pe, output logic fe, output logic ov);
        @(negedge clk);
        v = rx_valid; d = rx_data; pe = rx_perr; fe = rx_ferr; ov = rx_ovr;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic v, pe, fe, ov;
        logic [7:0] d;
        int m, half, nb, dc0, b0, e0, n1;

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 rx_valid after reset", int'(rx_valid), 0);
        chk("R11 strobes after reset", int'({char_done, brk_begin, brk_end}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 still empty", int'(rx_valid), 0);

        for (int k = 0; k < NV; k++) begin
            logic [22:0] vv;
            vv = VECS[k];
            dc0 = done_cnt;
            send_frame(vv[22:21], vv[20:19], vv[18], vv[17], vv[16], vv[15:8], 1'b1, 2);
            m    = ticks(vv[22:21]);
            half = (vv[22:21] == 2'd0) ? 0 : m / 2;
            nb   = 5 + int'(vv[20:19]) + int'(vv[18]);
            chk("R3 char_done cycle", last_done - frame_neg, 1 + half + m * (nb + 1));
            chk("R10 one pulse per char", done_cnt - dc0, 1);
            pop(v, d, pe, fe, ov);
            chk("R7 entry valid", int'(v), 1);
            chk("R1 data", int'(d), int'(vv[7:0]));
            chk("R2 parity flag", int'(pe), int'(vv[18] & vv[16]));
            chk("R5 good stop", int'(fe), 0);
            @(negedge clk);
            chk("R7 empty after pop", int'(rx_valid), 0);
        end

        // R4: low lasting exactly half a bit is rejected at the recheck
        cfg_mult = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0;
        dc0 = done_cnt;
        @(negedge clk); rxd = 1'b0;
        repeat (7) @(negedge clk);
        @(negedge clk); rxd = 1'b1;
        repeat (200) @(negedge clk);
        chk("R4 spike gives no char", done_cnt - dc0, 0);
        chk("R4 spike leaves queue empty", int'(rx_valid), 0);
        send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b1, 2);
        pop(v, d, pe, fe, ov);
        chk("R4 next char intact", int'(d), 8'h3C);

        // R5/R6: framing error then back-to-back frame with no idle gap
        send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 0);
        send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'hA3, 1'b1, 2);
        n1 = frame_neg;
        // hunting resumes one tick after the new start edge
        chk("R6 hold-off delays next start", last_done - n1, 154);
        pop(v, d, pe, fe, ov);
        chk("R5 framed char data", int'(d), 8'h55);
        chk("R5 framing flag set", int'(fe), 1);
        pop(v, d, pe, fe, ov);
        chk("R6 following char data", int'(d), 8'hA3);
        chk("R5 following char no framing", int'(fe), 0);

        // R8: four chars without reading
        send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h11, 1'b1, 1);
        send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h22, 1'b1, 1);
        send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h33, 1'b1, 1);
        send_frame(2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 8'h44, 1'b1, 1);
        pop(v, d, pe, fe, ov);
        chk("R8 oldest kept", int'({d, ov}), int'({8'h11, 1'b0}));
        pop(v, d, pe, fe, ov);
        chk("R8 second kept", int'({d, ov}), int'({8'h22, 1'b0}));
        pop(v, d, pe, fe, ov);
        chk("R8 newest replaced with flag", int'({d, ov}), int'({8'h44, 1'b1}));
        @(negedge clk);
        chk("R7 three entries only", int'(rx_valid), 0);

        // R9: break
        cfg_mult = 2'd1; cfg_len = 2'd3; cfg_par_en = 1'b0;
        b0 = bb_cnt; e0 = be_cnt;
        @(negedge clk); rxd = 1'b0;
        repeat (12 * 16 - 1) @(negedge clk);
        chk("R9 break begin pulse", bb_cnt - b0, 1);
        chk("R9 no end while low", be_cnt - e0, 0);
        @(negedge clk); rxd = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 break end pulse", be_cnt - e0, 1);
        pop(v, d, pe, fe, ov);
        chk("R9 break char stored", int'({v, d, fe}), int'({1'b1, 8'h00, 1'b1}));

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule